// File: doc/BRIEF.md
# DRAM Power-Up Command Sequencer

This block brings external DRAM out of power-up by issuing the required start-up command stream, one command word at a time, toward a memory controller's direct-command input. A single start pulse launches the run. The memory type present at that pulse selects one of three command orders, for DDR2, LPDDR or LPDDR2. The order is played for chip 0, and then a second time for chip 1 if a second chip was enabled at start. When the last command is accepted, the block raises done.

Each command is a 32-bit word that packs an operation code, a bank, a chip select and an address. The mode-register value it programs is built at elaboration time from the write-recovery, CAS-latency and burst-length parameters. On the LPDDR2 path, the block reads a mode register over and over until the memory's status bit reports that auto-initialisation has finished.

Top module: `dram_init_seq`

## Requirements
- R1: After reset, `cmd_valid_o`, `busy_o` and `done_o` are all low.
- R2: A command word has its code in bits [27:24], the chip in bit 20, the bank in bits [17:16] and the address in bits [15:0]. All other bits are zero. The codes are: mode-set 0, precharge-all 1, refresh 5, no-op 7, mode-read 9. An extended mode-set to register n is a mode-set with bank n.
- R3: With `mem_type_i` at 0 (DDR2), or at 3 (which behaves the same), the order is as follows. No-op, precharge-all, EMR2, EMR3, EMR1(0x400), MR(mr|0x100), precharge-all, refresh, refresh, MR(mr), EMR1(0x780), EMR1(0x400).
- R4: With `mem_type_i` at 1 (LPDDR), the order is precharge-all, refresh, refresh, MR(mr), EMR1(0x400).
- R5: With `mem_type_i` at 2 (LPDDR2), the order is no-op, then MR(mr), then mode-read. The mode-read is issued again each time `mr_busy_i` is high at its acknowledge. The run moves on at the first acknowledge where `mr_busy_i` is low.
- R6: mr = ((WR-1)<<9) | (CAS<<4) | code, where the code is 2 for burst 4 and 3 for burst 8. With the defaults (WR=3, CAS=4, burst 4), mr is 0x442.
- R7: The whole order is repeated with bit 20 set only when `two_chip_i` was high at the start pulse.
- R8: `cmd_valid_o` is high for exactly one cycle per command. The word stays stable until `cmd_ack_i`, which is sampled only in the cycles after that strobe. The next command strobes in the cycle after the acknowledge.
- R9: A start pulse while `busy_o` is high is ignored. The running order, type and chip count are unchanged.
- R10: `done_o` rises in the cycle after the final acknowledge, with `busy_o` low. It stays high until the next accepted start, which clears it in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| mem_type_i | input | 2 | Memory type: 0 DDR2, 1 LPDDR, 2 LPDDR2, 3 as DDR2 |
| two_chip_i | input | 1 | Second chip present; sampled at start |
| cmd_ack_i | input | 1 | Command accepted |
| mr_busy_i | input | 1 | Mode-register status bit 0, sampled with each acknowledge |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_word_o | output | 32 | Command word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |

## Verification
A wrong step index or chip bit appears on the very next strobe as a wrong code, bank, chip or address. It is caught on the same cycle that `cmd_valid_o` rises. A broken polling or chip-repeat decision shows up in one of two ways: as an extra or missing command at the end of an order, or as `done_o` rising early or late by at least one command slot. Lost handshake state shows up as a strobe wider than one cycle, or as a word that changes while the sequencer waits for its acknowledge.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

    localparam int unsigned CMD_ADDR_W = 16;
    localparam int unsigned STEP_W     = 4;

    typedef enum logic [3:0] {
        CMD_MRS   = 4'd0,
        CMD_PALL  = 4'd1,
        CMD_PRE   = 4'd2,
        CMD_DPD   = 4'd3,
        CMD_REFS  = 4'd4,
        CMD_REFA  = 4'd5,
        CMD_CKEL  = 4'd6,
        CMD_NOP   = 4'd7,
        CMD_REFSX = 4'd8,
        CMD_MRR   = 4'd9
    } dram_cmd_e;

    typedef enum logic [1:0] {
        MEM_DDR2   = 2'd0,
        MEM_LPDDR  = 2'd1,
        MEM_LPDDR2 = 2'd2,
        MEM_RSVD   = 2'd3
    } mem_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        dram_cmd_e              cmd;
        logic [1:0]             bank;
        logic [CMD_ADDR_W-1:0]  addr;
        logic                   last;
        logic                   poll;
    } seq_entry_t;

    typedef struct packed {
        seq_state_e         state;
        logic [STEP_W-1:0]  step;
        logic               chip;
        logic               two_chip;
        mem_kind_e          kind;
        logic               done;
    } seq_regs_t;

endpackage

// File: rtl/dram_mode_word.sv
module dram_mode_word
    import dram_init_pkg::*;
#(
    parameter int unsigned WR_CYC    = 3,
    parameter int unsigned CAS_CYC   = 4,
    parameter int unsigned BURST_LEN = 4
) (
    output logic [CMD_ADDR_W-1:0] mr_plain_o,
    output logic [CMD_ADDR_W-1:0] mr_dll_rst_o
);
    localparam int unsigned BURST_CODE = (BURST_LEN == 8) ? 3 : 2;
    localparam int unsigned MR_VAL     = ((WR_CYC - 1) << 9) | (CAS_CYC << 4) | BURST_CODE;
    localparam int unsigned DLL_RST    = 32'h100;

    assign mr_plain_o   = CMD_ADDR_W'(MR_VAL);
    assign mr_dll_rst_o = CMD_ADDR_W'(MR_VAL | DLL_RST);
endmodule

// File: rtl/dram_seq_rom.sv
module dram_seq_rom
    import dram_init_pkg::*;
(
    input  mem_kind_e              kind_i,
    input  logic [STEP_W-1:0]      step_i,
    input  logic [CMD_ADDR_W-1:0]  mr_plain_i,
    input  logic [CMD_ADDR_W-1:0]  mr_dll_rst_i,
    output seq_entry_t             entry_o
);
    localparam logic [CMD_ADDR_W-1:0] EMR_BASE = CMD_ADDR_W'(16'h0400);
    localparam logic [CMD_ADDR_W-1:0] EMR_OCD  = CMD_ADDR_W'(16'h0780);

    function automatic seq_entry_t mk(dram_cmd_e c, logic [1:0] b,
                                      logic [CMD_ADDR_W-1:0] a, logic l, logic p);
        seq_entry_t e;
        e.cmd  = c;
        e.bank = b;
        e.addr = a;
        e.last = l;
        e.poll = p;
        return e;
    endfunction

    always_comb begin
        entry_o = mk(CMD_NOP, 2'd0, '0, 1'b1, 1'b0);
        case (kind_i)
            MEM_LPDDR: begin
                case (step_i)
                    4'd0:    entry_o = mk(CMD_PALL, 2'd0, '0,         1'b0, 1'b0);
                    4'd1:    entry_o = mk(CMD_REFA, 2'd0, '0,         1'b0, 1'b0);
                    4'd2:    entry_o = mk(CMD_REFA, 2'd0, '0,         1'b0, 1'b0);
                    4'd3:    entry_o = mk(CMD_MRS,  2'd0, mr_plain_i, 1'b0, 1'b0);
                    default: entry_o = mk(CMD_MRS,  2'd1, EMR_BASE,   1'b1, 1'b0);
                endcase
            end
            MEM_LPDDR2: begin
                case (step_i)
                    4'd0:    entry_o = mk(CMD_NOP, 2'd0, '0,         1'b0, 1'b0);
                    4'd1:    entry_o = mk(CMD_MRS, 2'd0, mr_plain_i, 1'b0, 1'b0);
                    default: entry_o = mk(CMD_MRR, 2'd0, '0,         1'b1, 1'b1);
                endcase
            end
            default: begin
                case (step_i)
                    4'd0:    entry_o = mk(CMD_NOP,  2'd0, '0,           1'b0, 1'b0);
                    4'd1:    entry_o = mk(CMD_PALL, 2'd0, '0,           1'b0, 1'b0);
                    4'd2:    entry_o = mk(CMD_MRS,  2'd2, '0,           1'b0, 1'b0);
                    4'd3:    entry_o = mk(CMD_MRS,  2'd3, '0,           1'b0, 1'b0);
                    4'd4:    entry_o = mk(CMD_MRS,  2'd1, EMR_BASE,     1'b0, 1'b0);
                    4'd5:    entry_o = mk(CMD_MRS,  2'd0, mr_dll_rst_i, 1'b0, 1'b0);
                    4'd6:    entry_o = mk(CMD_PALL, 2'd0, '0,           1'b0, 1'b0);
                    4'd7:    entry_o = mk(CMD_REFA, 2'd0, '0,           1'b0, 1'b0);
                    4'd8:    entry_o = mk(CMD_REFA, 2'd0, '0,           1'b0, 1'b0);
                    4'd9:    entry_o = mk(CMD_MRS,  2'd0, mr_plain_i,   1'b0, 1'b0);
                    4'd10:   entry_o = mk(CMD_MRS,  2'd1, EMR_OCD,      1'b0, 1'b0);
                    default: entry_o = mk(CMD_MRS,  2'd1, EMR_BASE,     1'b1, 1'b0);
                endcase
            end
        endcase
    end
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
    import dram_init_pkg::*;
#(
    parameter int unsigned WR_CYC    = 3,
    parameter int unsigned CAS_CYC   = 4,
    parameter int unsigned BURST_LEN = 4,
    parameter int unsigned WORD_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mem_type_i,
    input  logic              two_chip_i,
    input  logic              cmd_ack_i,
    input  logic              mr_busy_i,
    output logic              cmd_valid_o,
    output logic [WORD_W-1:0] cmd_word_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int unsigned CODE_LSB = 24;
    localparam int unsigned CHIP_BIT = 20;
    localparam int unsigned BANK_LSB = 16;

    seq_regs_t r_d, r_q;
    seq_entry_t entry;
    logic [CMD_ADDR_W-1:0] mr_plain, mr_dll_rst;

    dram_mode_word #(
        .WR_CYC   (WR_CYC),
        .CAS_CYC  (CAS_CYC),
        .BURST_LEN(BURST_LEN)
    ) i_mode_word (
        .mr_plain_o  (mr_plain),
        .mr_dll_rst_o(mr_dll_rst)
    );

    dram_seq_rom i_seq_rom (
        .kind_i      (r_q.kind),
        .step_i      (r_q.step),
        .mr_plain_i  (mr_plain),
        .mr_dll_rst_i(mr_dll_rst),
        .entry_o     (entry)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state    = ST_ISSUE;
                    r_d.step     = '0;
                    r_d.chip     = 1'b0;
                    r_d.two_chip = two_chip_i;
                    r_d.kind     = mem_kind_e'(mem_type_i);
                    r_d.done     = 1'b0;
                end
            end
            ST_ISSUE: r_d.state = ST_WAIT;
            ST_WAIT: begin
                if (cmd_ack_i) begin
                    if (entry.poll && mr_busy_i) begin
                        r_d.state = ST_ISSUE;
                    end else if (entry.last) begin
                        if (!r_q.chip && r_q.two_chip) begin
                            r_d.chip  = 1'b1;
                            r_d.step  = '0;
                            r_d.state = ST_ISSUE;
                        end else begin
                            r_d.state = ST_IDLE;
                            r_d.done  = 1'b1;
                        end
                    end else begin
                        r_d.step  = r_q.step + 1'b1;
                        r_d.state = ST_ISSUE;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.step     <= '0;
            r_q.chip     <= 1'b0;
            r_q.two_chip <= 1'b0;
            r_q.kind     <= MEM_DDR2;
            r_q.done     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        cmd_word_o = '0;
        cmd_word_o[CODE_LSB +: 4]       = entry.cmd;
        cmd_word_o[CHIP_BIT]            = r_q.chip;
        cmd_word_o[BANK_LSB +: 2]       = entry.bank;
        cmd_word_o[0 +: CMD_ADDR_W]     = entry.addr;
    end

    assign cmd_valid_o = (r_q.state == ST_ISSUE);
    assign busy_o      = (r_q.state != ST_IDLE);
    assign done_o      = r_q.done;
endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        cmd_ack_i,
    input logic        cmd_valid_o,
    input logic [31:0] cmd_word_o,
    input logic        busy_o,
    input logic        done_o
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o); // R8
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> $stable(cmd_word_o)); // R8
    AST_STROBE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> busy_o); // R8
    AST_FIELDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cmd_word_o[31:28] == 4'd0 && cmd_word_o[23:21] == 3'd0
                         && cmd_word_o[19:18] == 2'd0 && cmd_word_o[27:24] <= 4'd9)); // R2
    AST_RUN_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o)); // R9
    AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R10
endmodule

bind dram_init_seq dram_init_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cmd_ack_i  (cmd_ack_i),
    .cmd_valid_o(cmd_valid_o),
    .cmd_word_o (cmd_word_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/test_dram_init_seq.sv
`timescale 1ns/1ps
module test_dram_init_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  kind = 2'd0;
    logic        two = 1'b0;
    logic        ack = 1'b0;
    logic        mrbusy = 1'b0;
    logic        valid, busy, done;
    logic [31:0] word;

    int checks = 0;
    int errors = 0;

    localparam int WR = 3, CAS = 4, BL = 4;
    localparam logic [15:0] MR = 16'(((WR - 1) << 9) | (CAS << 4) | ((BL == 8) ? 3 : 2));

    always #2 clk = ~clk;

    dram_init_seq i_dram_init_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mem_type_i(kind),
        .two_chip_i(two), .cmd_ack_i(ack), .mr_busy_i(mrbusy),
        .cmd_valid_o(valid), .cmd_word_o(word), .busy_o(busy), .done_o(done)
    );

    // kind[13:12] two[11] delay[10:7] polls[6:3] intrude[2] spare[1:0]
    localparam int NV = 8;
    localparam logic [13:0] VEC [NV] = '{
        {2'd0, 1'b0, 4'd1, 4'd0, 1'b0, 2'b00},
        {2'd0, 1'b1, 4'd3, 4'd0, 1'b1, 2'b00},
        {2'd1, 1'b0, 4'd2, 4'd0, 1'b0, 2'b00},
        {2'd1, 1'b1, 4'd1, 4'd0, 1'b0, 2'b00},
        {2'd2, 1'b0, 4'd1, 4'd0, 1'b0, 2'b00},
        {2'd2, 1'b0, 4'd2, 4'd3, 1'b0, 2'b00},
        {2'd2, 1'b1, 4'd1, 4'd2, 1'b0, 2'b00},
        {2'd3, 1'b0, 4'd1, 4'd0, 1'b0, 2'b00}
    };

    logic [31:0] exp_w [64];
    logic        exp_s [64];
    int          n_exp;

    function automatic logic [31:0] mk(input logic [3:0] c, input logic [1:0] b,
                                       input logic ch, input logic [15:0] a);
        return {4'd0, c, 3'd0, ch, 2'd0, b, a};
    endfunction

    task automatic add(input logic [31:0] w, input logic s);
        exp_w[n_exp] = w;
        exp_s[n_exp] = s;
        n_exp++;
    endtask

    task automatic build(input logic [1:0] k, input logic tc, input int polls);
        n_exp = 0;
        for (int ch = 0; ch <= (tc ? 1 : 0); ch++) begin
            logic c;
            c = ch[0];
            if (k == 2'd1) begin
                add(mk(4'd1, 2'd0, c, 16'h0), 1'b0);
                add(mk(4'd5, 2'd0, c, 16'h0), 1'b0);
                add(mk(4'd5, 2'd0, c, 16'h0), 1'b0);
                add(mk(4'd0, 2'd0, c, MR), 1'b0);
                add(mk(4'd0, 2'd1, c, 16'h0400), 1'b0);
            end else if (k == 2'd2) begin
                add(mk(4'd7, 2'd0, c, 16'h0), 1'b0);
                add(mk(4'd0, 2'd0, c, MR), 1'b0);
                for (int p = 0; p <= polls; p++) add(mk(4'd9, 2'd0, c, 16'h0), p < polls);
            end else begin
                add(mk(4'd7, 2'd0, c, 16'h0), 1'b0);
                add(mk(4'd1, 2'd0, c, 16'h0), 1'b0);
                add(mk(4'd0, 2'd2, c, 16'h0), 1'b0);
                add(mk(4'd0, 2'd3, c, 16'h0), 1'b0);
                add(mk(4'd0, 2'd1, c, 16'h0400), 1'b0);
                add(mk(4'd0, 2'd0, c, MR | 16'h0100), 1'b0);
                add(mk(4'd1, 2'd0, c, 16'h0), 1'b0);
                add(mk(4'd5, 2'd0, c, 16'h0), 1'b0);
                add(mk(4'd5, 2'd0, c, 16'h0), 1'b0);
                add(mk(4'd0, 2'd0, c, MR), 1'b0);
                add(mk(4'd0, 2'd1, c, 16'h0780), 1'b0);
                add(mk(4'd0, 2'd1, c, 16'h0400), 1'b0);
            end
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [13:0] v);
        logic [1:0]  k;
        logic        tc, intr;
        int          dly, polls;
        logic [31:0] held;
        string       tag;
        k = v[13:12]; tc = v[11]; dly = int'(v[10:7]); polls = int'(v[6:3]); intr = v[2];
        build(k, tc, polls);
        tag = (k == 2'd1) ? "R4" : (k == 2'd2) ? "R5" : "R3";
        @(negedge clk); kind = k; two = tc; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy && !done, "R10 start clears done", {30'd0, busy, done}, 32'd2);
        for (int i = 0; i < n_exp; i++) begin
            int guard;
            guard = 0;
            while (!valid && guard < 50) begin @(negedge clk); guard++; end
            chk(valid && word == exp_w[i],
                (exp_w[i][20]) ? {tag, " R7 chip1 word"} :
                (exp_w[i][27:16] == 12'h000 && exp_w[i][15:0] != 16'h0) ? {tag, " R6 mode word"} : tag,
                word, exp_w[i]);
            chk(word[31:28] == 4'd0 && word[23:21] == 3'd0 && word[19:18] == 2'd0,
                "R2 reserved bits", word, word & 32'h0F13FFFF);
            held = word;
            for (int d = 0; d < dly; d++) begin
                @(negedge clk);
                if (intr && i == 2 && d == 0) begin start = 1'b1; kind = 2'd1; two = ~tc; end
                else start = 1'b0;
                chk(!valid && word == held, "R8 strobe/hold", word, held);
            end
            start = 1'b0;
            mrbusy = exp_s[i]; ack = 1'b1;
            @(negedge clk);
            ack = 1'b0; mrbusy = 1'b0;
        end
        chk(done && !busy && !valid, "R10 done after last ack", {29'd0, done, busy, valid}, 32'd4);
        if (intr) chk(done, "R9 busy start ignored", {31'd0, done}, 32'd1);
        repeat (4) @(negedge clk);
        chk(done && !valid && !busy, "R10 done holds", {29'd0, done, busy, valid}, 32'd4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!valid && !busy && !done, "R1 reset state", {29'd0, valid, busy, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid && !busy && !done, "R1 after release", {29'd0, valid, busy, done}, 32'd0);
        // ack while idle must not launch anything
        ack = 1'b1; @(negedge clk); ack = 1'b0; @(negedge clk);
        chk(!valid && !busy, "R9 idle ack ignored", {30'd0, valid, busy}, 32'd0);
        for (int n = 0; n < NV; n++) run_case(VEC[n]);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule